// File: doc/BRIEF.md
# Playfield Fetch Scheduler

This block decides, cycle by cycle across a scanline, when a video display processor must take the memory bus to fetch playfield data. It also decides which kind of fetch it makes and which address it drives. Three things set the schedule: the display mode of the current row, the playfield width, and the horizontal cycle count. Character modes fetch character names and then glyph bytes. Bitmap modes fetch pixel bytes directly. Every fetch cycle also stalls the processor.

A row of the display can span several scan lines. The block stores the bytes fetched on the first line of the row, name or bitmap, in a line buffer. Bitmap bytes are replayed from that buffer on later lines without touching memory. Stored character names form the glyph addresses on every line. A scan pointer supplies the name and bitmap addresses. It is loaded from outside and advances only on fetches that consume it.

Top module: `pf_fetch_sched`

## Requirements
- R1: Bitmap modes fetch at a fixed cadence: modes 8 and 9 every 8 cycles, modes A, B and C every 4 cycles, and modes D, E and F every 2 cycles.
- R2: Character modes 2 to 5 issue a name fetch every 2 cycles. Character modes 6 and 7 issue one every 4 cycles. Each name fetch is followed 3 cycles later by a glyph fetch with the same index.
- R3: The first bitmap fetch falls on cycle 28 for width_sel 0 (narrow), 20 for width_sel 1 (normal) and 12 for width_sel 2 or 3 (wide). The first name fetch falls 2 cycles before that cycle, and the first glyph fetch 1 cycle after it.
- R4: The fetch window is 64, 80 or 96 cycles long for narrow, normal and wide. A fetch index k is issued only while k times the cadence is below the window length.
- R5: Name and bitmap fetches occur only while first_line is 1. Glyph fetches occur on every line of the row.
- R6: In modes 2 to 5 the glyph address is {chbase[7:2], name[6:0], row_line[2:0]}. In modes 6 and 7 it is {chbase[7:1], name[5:0], row_line[2:0]}. In both cases name is the byte stored by name fetch k.
- R7: halt_cpu is 1 in exactly the cycles where dma_req is 1.
- R8: Name and bitmap fetches drive the scan pointer as their address. The pointer increments by one after each such fetch and loads scan_addr when scan_load is 1. A load in the same cycle as a fetch wins over the increment.
- R9: data_strobe is 1 in every bitmap slot on every line. data_out carries mem_data on the first line and the byte stored by bitmap fetch k on later lines.
- R10: Modes 0 and 1 issue no fetches.
- R11: fetch_kind encodes 0 for name, 1 for bitmap and 2 for glyph. When dma_req is 0, fetch_kind and fetch_addr are 0.
- R12: Reset clears the scan pointer to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_mode | input | 4 | Display mode of the current row |
| width_sel | input | 2 | 0 narrow, 1 normal, 2 or 3 wide |
| hcount | input | 8 | Horizontal cycle count |
| first_line | input | 1 | Current line is the first of its row |
| row_line | input | 3 | Line number within the character row |
| chbase | input | 8 | Character base register |
| scan_load | input | 1 | Load the scan pointer |
| scan_addr | input | 16 | Value to load into the scan pointer |
| mem_data | input | 8 | Memory read data in the fetch cycle |
| dma_req | output | 1 | Playfield fetch this cycle |
| halt_cpu | output | 1 | Processor stall this cycle |
| fetch_kind | output | 2 | Kind of fetch |
| fetch_addr | output | 16 | Fetch address |
| data_strobe | output | 1 | Bitmap byte valid on data_out |
| data_out | output | 8 | Bitmap byte, live or replayed |

## Verification
Two functions can fall in the same cycle: a scan pointer load and a fetch that would advance the pointer. The bench provokes this by raising scan_load on the first bitmap slot of a narrow line. It then requires that the slot drives the old pointer and that the next slot drives the loaded value rather than the old value plus one. A second overlap exists in character modes, where the buffer is written by a name fetch while a glyph fetch reads an earlier entry. The bench judges this overlap by recomputing every glyph address from the names it supplied itself.

// File: rtl/pf_sched_pkg.sv
package pf_sched_pkg;

    localparam int HCNT_W = 8;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        FK_NAME   = 2'd0,
        FK_BITMAP = 2'd1,
        FK_GLYPH  = 2'd2
    } fetch_kind_e;

    typedef enum logic [2:0] {
        GRP_NONE,
        GRP_CHR2,
        GRP_CHR4,
        GRP_MAP8,
        GRP_MAP4,
        GRP_MAP2
    } mode_grp_e;

    typedef struct packed {
        logic              hit;
        logic [HCNT_W-1:0] idx;
    } slot_t;

    function automatic mode_grp_e grp_of(input logic [3:0] m);
        case (m)
            4'h2, 4'h3, 4'h4, 4'h5: grp_of = GRP_CHR2;
            4'h6, 4'h7:             grp_of = GRP_CHR4;
            4'h8, 4'h9:             grp_of = GRP_MAP8;
            4'hA, 4'hB, 4'hC:       grp_of = GRP_MAP4;
            4'hD, 4'hE, 4'hF:       grp_of = GRP_MAP2;
            default:                grp_of = GRP_NONE;
        endcase
    endfunction

    function automatic logic is_mapped(input mode_grp_e g);
        is_mapped = (g == GRP_MAP8) || (g == GRP_MAP4) || (g == GRP_MAP2);
    endfunction

    function automatic logic is_char(input mode_grp_e g);
        is_char = (g == GRP_CHR2) || (g == GRP_CHR4);
    endfunction

    // log2 of the fetch cadence in cycles
    function automatic logic [1:0] step_lg(input mode_grp_e g);
        case (g)
            GRP_CHR4, GRP_MAP4: step_lg = 2'd2;
            GRP_MAP8:           step_lg = 2'd3;
            default:            step_lg = 2'd1;
        endcase
    endfunction

    // cycle of the first name fetch; bitmap is +2, glyph is +3
    function automatic logic [HCNT_W-1:0] name_base(input logic [1:0] w);
        case (w)
            2'd0:    name_base = HCNT_W'(26);
            2'd1:    name_base = HCNT_W'(18);
            default: name_base = HCNT_W'(10);
        endcase
    endfunction

    function automatic logic [HCNT_W-1:0] window_len(input logic [1:0] w);
        case (w)
            2'd0:    window_len = HCNT_W'(64);
            2'd1:    window_len = HCNT_W'(80);
            default: window_len = HCNT_W'(96);
        endcase
    endfunction

    function automatic slot_t slot_match(input logic [HCNT_W-1:0] h,
                                         input logic [HCNT_W-1:0] off,
                                         input logic [HCNT_W-1:0] len,
                                         input logic [1:0]        lg);
        logic [HCNT_W-1:0] d;
        logic [HCNT_W-1:0] m;
        d = h - off;
        m = (HCNT_W'(1) << lg) - HCNT_W'(1);
        slot_match.hit = (h >= off) && (d < len) && ((d & m) == '0);
        slot_match.idx = d >> lg;
    endfunction

endpackage

// File: rtl/pf_slot_decode.sv
module pf_slot_decode
    import pf_sched_pkg::*;
(
    input  mode_grp_e         grp,
    input  logic [1:0]        width_sel,
    input  logic [HCNT_W-1:0] hcount,
    input  logic              first_line,
    output logic              req,
    output fetch_kind_e       kind,
    output logic [HCNT_W-1:0] idx,
    output logic              map_slot,
    output logic [HCNT_W-1:0] map_idx
);
    localparam int NSLOT = 3;
    localparam logic [HCNT_W-1:0] OFFS [NSLOT] = '{HCNT_W'(0), HCNT_W'(2), HCNT_W'(3)};

    logic [HCNT_W-1:0] base;
    logic [HCNT_W-1:0] len;
    logic [1:0]        lg;
    slot_t             slot [NSLOT];

    assign base = name_base(width_sel);
    assign len  = window_len(width_sel);
    assign lg   = step_lg(grp);

    // slot 0 name, slot 1 bitmap, slot 2 glyph
    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        assign slot[i] = slot_match(hcount, base + OFFS[i], len, lg);
    end

    assign map_slot = is_mapped(grp) && slot[1].hit;
    assign map_idx  = slot[1].idx;

    always_comb begin
        req  = 1'b0;
        kind = FK_NAME;
        idx  = '0;
        if (is_mapped(grp)) begin
            if (first_line && slot[1].hit) begin
                req  = 1'b1;
                kind = FK_BITMAP;
                idx  = slot[1].idx;
            end
        end else if (is_char(grp)) begin
            if (first_line && slot[0].hit) begin
                req  = 1'b1;
                kind = FK_NAME;
                idx  = slot[0].idx;
            end else if (slot[2].hit) begin
                req  = 1'b1;
                kind = FK_GLYPH;
                idx  = slot[2].idx;
            end
        end
    end

endmodule

// File: rtl/pf_line_buf.sv
module pf_line_buf #(
    parameter int DEPTH = 48,
    parameter int IDX_W = 8,
    parameter int DW    = 8
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [DW-1:0]    wdata,
    input  logic [IDX_W-1:0] ridx_a,
    output logic [DW-1:0]    rdata_a,
    input  logic [IDX_W-1:0] ridx_b,
    output logic [DW-1:0]    rdata_b
);
    logic [DW-1:0] mem [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        always_ff @(posedge clk) begin
            if (we && (widx == IDX_W'(i)))
                mem[i] <= wdata;
        end
    end

    always_comb begin
        rdata_a = '0;
        rdata_b = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (ridx_a == IDX_W'(i)) rdata_a = mem[i];
            if (ridx_b == IDX_W'(i)) rdata_b = mem[i];
        end
    end

endmodule

// File: rtl/pf_scan_ctr.sv
module pf_scan_ctr #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          inc,
    output logic [AW-1:0] ptr
);
    always_ff @(posedge clk) begin
        if (rst)       ptr <= '0;
        else if (load) ptr <= load_val;
        else if (inc)  ptr <= ptr + AW'(1);
    end
endmodule

// File: rtl/pf_fetch_sched.sv
module pf_fetch_sched
    import pf_sched_pkg::*;
#(
    parameter int BUF_DEPTH = 48
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        disp_mode,
    input  logic [1:0]        width_sel,
    input  logic [HCNT_W-1:0] hcount,
    input  logic              first_line,
    input  logic [2:0]        row_line,
    input  logic [7:0]        chbase,
    input  logic              scan_load,
    input  logic [ADDR_W-1:0] scan_addr,
    input  logic [DATA_W-1:0] mem_data,
    output logic              dma_req,
    output logic              halt_cpu,
    output logic [1:0]        fetch_kind,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic              data_strobe,
    output logic [DATA_W-1:0] data_out
);
    mode_grp_e         grp;
    logic              hit;
    fetch_kind_e       kind;
    logic [HCNT_W-1:0] idx;
    logic              map_slot;
    logic [HCNT_W-1:0] map_idx;
    logic              ptr_use;
    logic [ADDR_W-1:0] scan_ptr;
    logic [DATA_W-1:0] name_byte;
    logic [DATA_W-1:0] replay_byte;
    logic [ADDR_W-1:0] hi_mask;
    logic [ADDR_W-1:0] glyph_addr;

    assign grp = grp_of(disp_mode);

    pf_slot_decode u_dec (
        .grp        (grp),
        .width_sel  (width_sel),
        .hcount     (hcount),
        .first_line (first_line),
        .req        (hit),
        .kind       (kind),
        .idx        (idx),
        .map_slot   (map_slot),
        .map_idx    (map_idx)
    );

    assign ptr_use = hit && (kind != FK_GLYPH);

    pf_line_buf #(.DEPTH(BUF_DEPTH), .IDX_W(HCNT_W), .DW(DATA_W)) u_buf (
        .clk     (clk),
        .we      (ptr_use),
        .widx    (idx),
        .wdata   (mem_data),
        .ridx_a  (idx),
        .rdata_a (name_byte),
        .ridx_b  (map_idx),
        .rdata_b (replay_byte)
    );

    pf_scan_ctr #(.AW(ADDR_W)) u_ctr (
        .clk      (clk),
        .rst      (rst),
        .load     (scan_load),
        .load_val (scan_addr),
        .inc      (ptr_use),
        .ptr      (scan_ptr)
    );

    // 1K-aligned base for the dense character group, 512-aligned otherwise
    assign hi_mask    = (grp == GRP_CHR4) ? 16'hFE00 : 16'hFC00;
    assign glyph_addr = ({chbase, 8'h00} & hi_mask)
                      | ({5'd0, name_byte, 3'd0} & ~hi_mask)
                      | {13'd0, row_line};

    assign dma_req     = hit;
    assign halt_cpu    = hit;
    assign fetch_kind  = hit ? kind : FK_NAME;
    assign fetch_addr  = !hit ? '0 : (kind == FK_GLYPH) ? glyph_addr : scan_ptr;
    assign data_strobe = map_slot;
    assign data_out    = !map_slot ? '0 : first_line ? mem_data : replay_byte;

endmodule

// File: rtl/pf_fetch_sched_chk.sv
module pf_fetch_sched_chk (
    input logic        clk,
    input logic        rst,
    input logic [3:0]  disp_mode,
    input logic [7:0]  hcount,
    input logic        first_line,
    input logic [7:0]  chbase,
    input logic        scan_load,
    input logic [15:0] scan_addr,
    input logic        dma_req,
    input logic [1:0]  fetch_kind,
    input logic [15:0] fetch_addr,
    input logic [15:0] scan_ptr,
    input logic        data_strobe
);
    p_blank_r10: assert property (@(posedge clk) disable iff (rst)
        (disp_mode < 4'h2) |-> !dma_req);

    p_later_line_r5: assert property (@(posedge clk) disable iff (rst)
        (!first_line && dma_req) |-> (fetch_kind == 2'd2));

    p_idle_r11: assert property (@(posedge clk) disable iff (rst)
        !dma_req |-> (fetch_addr == 16'd0 && fetch_kind == 2'd0));

    p_window_r4: assert property (@(posedge clk) disable iff (rst)
        dma_req |-> (hcount >= 8'd10 && hcount < 8'd108));

    p_ptr_inc_r8: assert property (@(posedge clk) disable iff (rst)
        (dma_req && fetch_kind != 2'd2 && !scan_load) |=> (scan_ptr == $past(fetch_addr) + 16'd1));

    p_load_wins_r8: assert property (@(posedge clk) disable iff (rst)
        scan_load |=> (scan_ptr == $past(scan_addr)));

    p_glyph_base_r6: assert property (@(posedge clk) disable iff (rst)
        (dma_req && fetch_kind == 2'd2 && disp_mode < 4'h6) |-> (fetch_addr[15:10] == chbase[7:2]));

    p_strobe_map_r9: assert property (@(posedge clk) disable iff (rst)
        data_strobe |-> (disp_mode >= 4'h8));
endmodule

bind pf_fetch_sched pf_fetch_sched_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .disp_mode  (disp_mode),
    .hcount     (hcount),
    .first_line (first_line),
    .chbase     (chbase),
    .scan_load  (scan_load),
    .scan_addr  (scan_addr),
    .dma_req    (dma_req),
    .fetch_kind (fetch_kind),
    .fetch_addr (fetch_addr),
    .scan_ptr   (scan_ptr),
    .data_strobe(data_strobe)
);

// File: tb/pf_fetch_sched_test.sv
module pf_fetch_sched_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  disp_mode = 4'h0;
    logic [1:0]  width_sel = 2'd0;
    logic [7:0]  hcount = 8'd0;
    logic        first_line = 1'b0;
    logic [2:0]  row_line = 3'd0;
    logic [7:0]  chbase = 8'hB6;
    logic        scan_load = 1'b0;
    logic [15:0] scan_addr = 16'd0;
    logic [7:0]  mem_data = 8'd0;
    logic        dma_req;
    logic        halt_cpu;
    logic [1:0]  fetch_kind;
    logic [15:0] fetch_addr;
    logic        data_strobe;
    logic [7:0]  data_out;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    pf_fetch_sched uut (
        .clk(clk), .rst(rst), .disp_mode(disp_mode), .width_sel(width_sel),
        .hcount(hcount), .first_line(first_line), .row_line(row_line),
        .chbase(chbase), .scan_load(scan_load), .scan_addr(scan_addr),
        .mem_data(mem_data), .dma_req(dma_req), .halt_cpu(halt_cpu),
        .fetch_kind(fetch_kind), .fetch_addr(fetch_addr),
        .data_strobe(data_strobe), .data_out(data_out)
    );

    // {mode, width, fetches on first line, fetches on a later line}
    localparam int NV = 12;
    localparam logic [21:0] VEC [NV] = '{
        {4'hF, 2'd0, 8'd32, 8'd0},
        {4'hE, 2'd2, 8'd48, 8'd0},
        {4'hA, 2'd1, 8'd20, 8'd0},
        {4'hC, 2'd0, 8'd16, 8'd0},
        {4'h8, 2'd2, 8'd12, 8'd0},
        {4'h9, 2'd1, 8'd10, 8'd0},
        {4'h2, 2'd2, 8'd96, 8'd48},
        {4'h4, 2'd0, 8'd64, 8'd32},
        {4'h6, 2'd1, 8'd40, 8'd20},
        {4'h7, 2'd2, 8'd48, 8'd24},
        {4'h0, 2'd1, 8'd0,  8'd0},
        {4'h1, 2'd2, 8'd0,  8'd0}
    };

    logic [7:0]  bufm [48];
    logic [15:0] ptr_m;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [3:0] m, input logic [1:0] w, input int h, input bit first,
                         input logic [2:0] row, input bit ld, input logic [15:0] la, input logic [7:0] md);
        @(negedge clk);
        disp_mode  = m;
        width_sel  = w;
        hcount     = 8'(h);
        first_line = first;
        row_line   = row;
        scan_load  = ld;
        scan_addr  = la;
        mem_data   = md;
        #1;
    endtask

    function automatic void model(input logic [3:0] m, input logic [1:0] w, input int h, input bit first,
                                  output bit req, output logic [1:0] kind, output int k,
                                  output bit mslot, output int mk);
        int base, len, c;
        bit isc, ism;
        base = (w == 2'd0) ? 26 : (w == 2'd1) ? 18 : 10;
        len  = (w == 2'd0) ? 64 : (w == 2'd1) ? 80 : 96;
        isc  = (m >= 4'h2) && (m <= 4'h7);
        ism  = (m >= 4'h8);
        c    = (m <= 4'h5) ? 2 : (m <= 4'h7) ? 4 : (m <= 4'h9) ? 8 : (m <= 4'hC) ? 4 : 2;
        req = 0; kind = 2'd0; k = 0; mslot = 0; mk = 0;
        if (ism && h >= base + 2 && (h - base - 2) < len && (h - base - 2) % c == 0) begin
            mslot = 1; mk = (h - base - 2) / c;
            if (first) begin req = 1; kind = 2'd1; k = mk; end
        end
        if (isc) begin
            if (first && h >= base && (h - base) < len && (h - base) % c == 0) begin
                req = 1; kind = 2'd0; k = (h - base) / c;
            end else if (h >= base + 3 && (h - base - 3) < len && (h - base - 3) % c == 0) begin
                req = 1; kind = 2'd2; k = (h - base - 3) / c;
            end
        end
    endfunction

    initial begin
        #(4 * 200000);
        fails++;
        tests++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [3:0] m;
        logic [1:0] w;
        logic [7:0] c1, c2;
        bit req, mslot, first;
        logic [1:0] kind;
        int k, mk, cnt;
        logic [15:0] eaddr;
        logic [7:0] md, nb, edata;
        logic [2:0] row;
        string tg;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R12: pointer is zero after reset
        drive(4'hF, 2'd0, 28, 1, 3'd0, 0, 16'd0, 8'd0);
        check(dma_req && fetch_addr == 16'd0, "R12 reset pointer", {15'd0, dma_req, fetch_addr}, 32'h0001_0000);
        // R11: idle outputs
        drive(4'hF, 2'd0, 5, 1, 3'd0, 0, 16'd0, 8'd0);
        check(!dma_req && fetch_kind == 2'd0 && fetch_addr == 16'd0, "R11 idle zero",
              {13'd0, dma_req, fetch_kind, fetch_addr}, 32'd0);

        for (int v = 0; v < NV; v++) begin
            m = VEC[v][21:18]; w = VEC[v][17:16]; c1 = VEC[v][15:8]; c2 = VEC[v][7:0];
            for (int ln = 0; ln < 2; ln++) begin
                cnt = 0;
                first = (ln == 0);
                row = first ? 3'd0 : 3'd5;
                for (int h = 0; h < 114; h++) begin
                    model(m, w, h, first, req, kind, k, mslot, mk);
                    if (!req) eaddr = 16'd0;
                    else if (kind != 2'd2) eaddr = ptr_m;
                    else begin
                        nb = bufm[k];
                        eaddr = (m <= 4'h5) ? {chbase[7:2], nb[6:0], row} : {chbase[7:1], nb[5:0], row};
                    end
                    md = (req && kind != 2'd2) ? (eaddr[7:0] ^ 8'hA5) : 8'hFF;
                    drive(m, w, h, first, row, first && h == 0, 16'h2000 + 16'(v * 256), md);
                    tg = (m >= 4'h8) ? "R1 cadence" : (m >= 4'h2) ? "R2 cadence" : "R10 blank";
                    check({dma_req, fetch_kind} == {req, kind}, tg, {29'd0, dma_req, fetch_kind}, {29'd0, req, kind});
                    check(fetch_addr == eaddr, (req && kind == 2'd2) ? "R6 glyph address" : "R8 scan address",
                          {16'd0, fetch_addr}, {16'd0, eaddr});
                    check(halt_cpu == req, "R7 halt", {31'd0, halt_cpu}, {31'd0, req});
                    edata = !mslot ? 8'd0 : first ? md : bufm[mk];
                    check({data_strobe, data_out} == {mslot, edata}, "R9 replay",
                          {23'd0, data_strobe, data_out}, {23'd0, mslot, edata});
                    if (req && kind != 2'd2) bufm[k] = md;
                    if (first && h == 0) ptr_m = 16'h2000 + 16'(v * 256);
                    else if (req && kind != 2'd2) ptr_m = ptr_m + 16'd1;
                    cnt += int'(req);
                end
                check(cnt == int'(first ? c1 : c2), first ? "R4 count first line" : "R5 count later line",
                      cnt, first ? c1 : c2);
            end
        end

        // R3 start cycles
        drive(4'hD, 2'd1, 19, 1, 3'd0, 0, 16'd0, 8'd0);
        check(!dma_req, "R3 normal before start", {31'd0, dma_req}, 0);
        drive(4'hD, 2'd1, 20, 1, 3'd0, 0, 16'd0, 8'd0);
        check(dma_req && fetch_kind == 2'd1, "R3 normal start", {29'd0, dma_req, fetch_kind}, 32'd5);
        drive(4'hE, 2'd2, 11, 1, 3'd0, 0, 16'd0, 8'd0);
        check(!dma_req, "R3 wide before start", {31'd0, dma_req}, 0);
        drive(4'hE, 2'd2, 12, 1, 3'd0, 0, 16'd0, 8'd0);
        check(dma_req, "R3 wide start", {31'd0, dma_req}, 1);
        drive(4'h2, 2'd0, 26, 1, 3'd0, 0, 16'd0, 8'd0);
        check(dma_req && fetch_kind == 2'd0, "R3 name start", {29'd0, dma_req, fetch_kind}, 32'd4);
        drive(4'h2, 2'd0, 29, 1, 3'd0, 0, 16'd0, 8'd0);
        check(dma_req && fetch_kind == 2'd2, "R3 glyph start", {29'd0, dma_req, fetch_kind}, 32'd6);

        // R4 end of window
        drive(4'hD, 2'd0, 90, 1, 3'd0, 0, 16'd0, 8'd0);
        check(dma_req, "R4 last narrow slot", {31'd0, dma_req}, 1);
        drive(4'hD, 2'd0, 92, 1, 3'd0, 0, 16'd0, 8'd0);
        check(!dma_req, "R4 past narrow end", {31'd0, dma_req}, 0);
        drive(4'h8, 2'd2, 100, 1, 3'd0, 0, 16'd0, 8'd0);
        check(dma_req, "R4 last sparse slot", {31'd0, dma_req}, 1);
        drive(4'h8, 2'd2, 108, 1, 3'd0, 0, 16'd0, 8'd0);
        check(!dma_req, "R4 past wide end", {31'd0, dma_req}, 0);

        // R5 later lines
        drive(4'hD, 2'd1, 20, 0, 3'd2, 0, 16'd0, 8'd0);
        check(!dma_req && data_strobe, "R5 bitmap slot later line", {30'd0, dma_req, data_strobe}, 32'd1);
        drive(4'h2, 2'd1, 18, 0, 3'd2, 0, 16'd0, 8'd0);
        check(!dma_req, "R5 name slot later line", {31'd0, dma_req}, 0);
        drive(4'h2, 2'd1, 21, 0, 3'd2, 0, 16'd0, 8'd0);
        check(dma_req && fetch_kind == 2'd2, "R5 glyph later line", {29'd0, dma_req, fetch_kind}, 32'd6);

        // R8 load colliding with a fetch
        drive(4'hD, 2'd0, 0, 1, 3'd0, 1, 16'h1234, 8'd0);
        drive(4'hD, 2'd0, 28, 1, 3'd0, 1, 16'h4000, 8'd0);
        check(fetch_addr == 16'h1234, "R8 fetch uses old pointer", {16'd0, fetch_addr}, 32'h1234);
        drive(4'hD, 2'd0, 29, 1, 3'd0, 0, 16'd0, 8'd0);
        drive(4'hD, 2'd0, 30, 1, 3'd0, 0, 16'd0, 8'd0);
        check(fetch_addr == 16'h4000, "R8 load beats increment", {16'd0, fetch_addr}, 32'h4000);
        drive(4'hD, 2'd0, 31, 1, 3'd0, 0, 16'd0, 8'd0);
        drive(4'hD, 2'd0, 32, 1, 3'd0, 0, 16'd0, 8'd0);
        check(fetch_addr == 16'h4001, "R8 increment after load", {16'd0, fetch_addr}, 32'h4001);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule